// File: doc/BRIEF.md
# Accumulator Machine Core

This block is a small multicycle processor. Programs see two pieces of state: a single accumulator and a program counter. Each instruction is a 16-bit word. The top four bits hold the operation code and the low twelve bits hold either a memory address or a signed constant. Four operations are defined: copy a memory word into the accumulator, write the accumulator to memory, add a signed constant to the accumulator, and branch unconditionally. Only the copy and write operations touch data memory. Arithmetic takes its second operand from the instruction itself.

Instructions and data share one internal word memory. The core reaches that memory through one port. A second, independent inspection port lets the surrounding logic or a testbench load programs and read results back. Reset clears the processor state but leaves memory untouched, so the usual flow is:
- hold reset,
- fill memory through the inspection port,
- release reset and wait for the halted flag.

None of the pins carries a data stream, so there is no valid/ready handshake. The inspection port accepts a request on every cycle and can never stall. Its read data follows the address by one clock.

Top module: `acc_core`

## Requirements
- R1: While reset is high at a clock edge, the program counter and accumulator become zero and the halted flag is low. Memory contents are not changed by reset.
- R2: Opcode 4'h1 (load) replaces the accumulator with the memory word at the address in the low bits of the instruction.
- R3: Opcode 4'h2 (store) writes the accumulator into memory at the instruction's address and leaves the accumulator unchanged.
- R4: Opcode 4'h3 (add constant) sign-extends bits [11:0] of the instruction to 16 bits and adds them to the accumulator, wrapping modulo 2^16.
- R5: Opcode 4'h4 (jump) loads the program counter with the instruction's address, and execution continues from that address.
- R6: Every non-halting instruction takes exactly three clocks (fetch, decode, execute), and the program counter advances by one at fetch. When K instructions precede a halting word at address K, halted goes high 3K+2 clock edges after reset is released.
- R7: Any other opcode (including 4'h0) halts the core. The program counter stays at the halting word's address plus one, the accumulator is frozen, no later instruction runs, and halted stays high until reset.
- R8: The inspection port writes memory on a clock edge where its write enable is high. Its read data shows the word at the address presented before the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of processor state |
| insp_addr | input | 8 | Inspection port word address |
| insp_we | input | 1 | Inspection port write enable |
| insp_wdata | input | 16 | Inspection port write data |
| insp_rdata | output | 16 | Inspection port read data, one clock after the address |
| pc_o | output | 8 | Current program counter |
| acc_o | output | 16 | Current accumulator |
| halted_o | output | 1 | High once an undefined opcode has been decoded |

## Verification
The bench runs a short load, add, store program over a table of operand pairs. The table covers negative constants, the most negative constant, and carries out of bit 15. A design that zero-extends the constant, or that drops the carry wrap, ends with the wrong accumulator and the wrong stored word.

A jump that skips over an add would expose a core that applies the branch late or also runs the skipped word. Counting clocks to the halt exposes a sequencer with a wrong number of states or a mistimed PC increment. A store placed right after a halting word catches a core that keeps running past a halt or moves its PC while halted. Reading memory back after a second reset catches a reset that wipes the memory.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OP_ADDI  = 4'h3;
  localparam logic [OPC_W-1:0] OP_JUMP  = 4'h4;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_HALT   = 2'd3
  } seq_state_e;

  function automatic logic op_known(input logic [OPC_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_STORE) ||
           (op == OP_ADDI) || (op == OP_JUMP);
  endfunction

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];
  logic              b_blocked;

  // the core port wins if both ports write the same word in one cycle
  assign b_blocked = a_we && (a_addr == b_addr);

  always_ff @(posedge clk) begin
    if (a_we) ram[a_addr] <= a_wdata;
    if (b_we && !b_blocked) ram[b_addr] <= b_wdata;
    a_rdata <= ram[a_addr];
    b_rdata <= ram[b_addr];
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OPND_W = 12
) (
  input  logic [OPC_W-1:0]  opc,
  input  logic [OPND_W-1:0] operand,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] mdata,
  output logic [DATA_W-1:0] acc_next
);
  localparam int EXT_W = DATA_W - OPND_W;

  logic [DATA_W-1:0] imm_ext;

  assign imm_ext = {{EXT_W{operand[OPND_W-1]}}, operand};

  always_comb begin
    case (opc)
      OP_LOAD: acc_next = mdata;
      OP_ADDI: acc_next = acc + imm_ext;
      default: acc_next = acc;
    endcase
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int OPND_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] acc_next,
  output logic [OPC_W-1:0]  opc,
  output logic [OPND_W-1:0] operand,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc,
  output logic              halted
);
  seq_state_e        state;
  logic [DATA_W-1:0] ir;
  logic [OPC_W-1:0]  fetched_opc;

  assign opc         = ir[DATA_W-1 -: OPC_W];
  assign operand     = ir[OPND_W-1:0];
  assign fetched_opc = mem_rdata[DATA_W-1 -: OPC_W];
  assign halted      = (state == ST_HALT);
  assign mem_we      = (state == ST_EXEC) && (opc == OP_STORE);
  assign mem_wdata   = acc;

  always_comb begin
    case (state)
      ST_DECODE: mem_addr = mem_rdata[ADDR_W-1:0];
      ST_EXEC:   mem_addr = ir[ADDR_W-1:0];
      default:   mem_addr = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH;
      pc    <= '0;
      acc   <= '0;
      ir    <= '0;
    end else begin
      case (state)
        ST_FETCH: begin
          pc    <= pc + 1'b1;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          ir    <= mem_rdata;
          state <= op_known(fetched_opc) ? ST_EXEC : ST_HALT;
        end
        ST_EXEC: begin
          acc <= acc_next;
          if (opc == OP_JUMP) pc <= ir[ADDR_W-1:0];
          state <= ST_FETCH;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (pc == $past(pc) + 1'b1));

  // R6
  seq_order_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE) |=> (state == ST_EXEC || state == ST_HALT));

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && opc == OP_LOAD) |=> (acc == $past(mem_rdata)));

  // R3
  store_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && opc == OP_STORE) |=> $stable(acc));

  // R5
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && opc == OP_JUMP) |=> (pc == $past(ir[ADDR_W-1:0])));

  // R7
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(acc) && !mem_we));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] insp_addr,
  input  logic              insp_we,
  input  logic [DATA_W-1:0] insp_wdata,
  output logic [DATA_W-1:0] insp_rdata,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              halted_o
);
  localparam int OPND_W = DATA_W - OPC_W;

  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] acc_next;
  logic [OPC_W-1:0]  opc;
  logic [OPND_W-1:0] operand;

  acc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .a_addr  (mem_addr),
    .a_we    (mem_we),
    .a_wdata (mem_wdata),
    .a_rdata (mem_rdata),
    .b_addr  (insp_addr),
    .b_we    (insp_we),
    .b_wdata (insp_wdata),
    .b_rdata (insp_rdata)
  );

  acc_alu #(.DATA_W(DATA_W), .OPND_W(OPND_W)) u_alu (
    .opc      (opc),
    .operand  (operand),
    .acc      (acc_o),
    .mdata    (mem_rdata),
    .acc_next (acc_next)
  );

  acc_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OPND_W(OPND_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .acc_next  (acc_next),
    .opc       (opc),
    .operand   (operand),
    .acc       (acc_o),
    .pc        (pc_o),
    .halted    (halted_o)
  );

endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  insp_addr = '0;
  logic        insp_we = 1'b0;
  logic [15:0] insp_wdata = '0;
  logic [15:0] insp_rdata;
  logic [7:0]  pc_o;
  logic [15:0] acc_o;
  logic        halted_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acc_core dut (
    .clk(clk), .rst(rst), .insp_addr(insp_addr), .insp_we(insp_we),
    .insp_wdata(insp_wdata), .insp_rdata(insp_rdata), .pc_o(pc_o),
    .acc_o(acc_o), .halted_o(halted_o)
  );

  // each entry: {start word [31:16], 4'h0, constant [11:0]}
  localparam logic [31:0] VEC [6] = '{
    32'h0005_0003, 32'h1234_07FF, 32'h0010_0FFF,
    32'h0000_0800, 32'hFFFF_0001, 32'h8000_0800
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    insp_addr = a; insp_wdata = d; insp_we = 1'b1;
    @(negedge clk);
    insp_we = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [15:0] d);
    insp_addr = a;
    @(negedge clk);
    d = insp_rdata;
  endtask

  task automatic run(output int edges);
    edges = 0;
    rst = 1'b0;
    while (!halted_o && edges < 2000) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic enter_reset();
    rst = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=halted");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int edges;
    logic [15:0] rd;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check(pc_o == 8'h00, "R1 pc", {24'h0, pc_o}, 32'h0);
    check(acc_o == 16'h0, "R1 acc", {16'h0, acc_o}, 32'h0);
    check(!halted_o, "R1 halted", {31'h0, halted_o}, 32'h0);

    // table: load, add constant, store, halt
    for (int i = 0; i < 6; i++) begin
      logic [15:0] a;
      logic [11:0] k;
      logic [15:0] exp;
      a = VEC[i][31:16];
      k = VEC[i][11:0];
      exp = a + {{4{k[11]}}, k};
      enter_reset();
      poke(8'h00, 16'h1080);
      poke(8'h01, {4'h3, k});
      poke(8'h02, 16'h2081);
      poke(8'h03, 16'hF000);
      poke(8'h80, a);
      poke(8'h81, 16'hDEAD);
      run(edges);
      // R2 R4 accumulator after load and add
      check(acc_o == exp, "R4 acc", {16'h0, acc_o}, {16'h0, exp});
      peek(8'h81, rd);
      // R3 stored word
      check(rd == exp, "R3 stored", {16'h0, rd}, {16'h0, exp});
      // R7 pc past halt word
      check(pc_o == 8'h04, "R7 pc", {24'h0, pc_o}, 32'h4);
      // R6 three cycles per instruction
      check(edges == 11, "R6 cycles", edges, 11);
    end

    // R1 reset from a non-zero state
    enter_reset();
    check(pc_o == 8'h00 && acc_o == 16'h0 && !halted_o, "R1 re-reset",
          {pc_o, acc_o, 7'h0, halted_o}, 32'h0);

    // R5 jump skips a word
    poke(8'h00, 16'h3001);
    poke(8'h01, 16'h4003);
    poke(8'h02, 16'h3064);
    poke(8'h03, 16'h3002);
    poke(8'h04, 16'h0000);
    run(edges);
    check(acc_o == 16'h0003, "R5 acc", {16'h0, acc_o}, 32'h3);
    check(pc_o == 8'h05, "R5 pc", {24'h0, pc_o}, 32'h5);
    check(edges == 11, "R6 jump cycles", edges, 11);

    // R2 load overwrites a non-zero accumulator
    enter_reset();
    poke(8'h00, 16'h3123);
    poke(8'h01, 16'h1090);
    poke(8'h02, 16'h2091);
    poke(8'h03, 16'hE000);
    poke(8'h90, 16'h0BEE);
    poke(8'h91, 16'h0000);
    run(edges);
    check(acc_o == 16'h0BEE, "R2 acc", {16'h0, acc_o}, 32'h0BEE);
    peek(8'h91, rd);
    check(rd == 16'h0BEE, "R3 store after load", {16'h0, rd}, 32'h0BEE);

    // R7 halt freezes and blocks the following store
    enter_reset();
    poke(8'h00, 16'h3005);
    poke(8'h01, 16'h5123);
    poke(8'h02, 16'h2092);
    poke(8'h92, 16'h1111);
    run(edges);
    for (int j = 0; j < 10; j++) @(negedge clk);
    check(halted_o, "R7 halted held", {31'h0, halted_o}, 32'h1);
    check(pc_o == 8'h02, "R7 pc frozen", {24'h0, pc_o}, 32'h2);
    check(acc_o == 16'h0005, "R7 acc frozen", {16'h0, acc_o}, 32'h5);
    peek(8'h92, rd);
    check(rd == 16'h1111, "R7 no store", {16'h0, rd}, 32'h1111);

    // R8 inspection write, one-cycle read, memory kept over reset
    poke(8'hA0, 16'h5A5A);
    poke(8'hA1, 16'hC3C3);
    enter_reset();
    enter_reset();
    peek(8'hA0, rd);
    check(rd == 16'h5A5A, "R8 kept over reset", {16'h0, rd}, 32'h5A5A);
    peek(8'hA1, rd);
    check(rd == 16'hC3C3, "R8 read latency", {16'h0, rd}, 32'hC3C3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule